// File: doc/BRIEF.md
# Maskable HDLC Address Recognition Filter

This block sits behind an HDLC deframer and decides, frame by frame, whether a received frame is meant for this station. It inspects the first one or two bytes of each frame, which form the address field, and compares them against two programmable address pairs. It also recognises two fixed group addresses. Frames that match are passed on as a byte stream. Frames that match nothing are swallowed completely.

The primary address pair has a per-bit wildcard mask: a mask bit at one makes that position match whatever value was received. This gives broadcast-style matching over a range of addresses. The secondary pair is always compared exactly. A control input chooses whether the address bytes are kept as the leading bytes of the forwarded frame or stripped off. Keeping them is useful when wildcard matching lets many addresses through and the consumer needs to know which one arrived. The decision is also presented as a status word. It becomes valid once the address field is complete and stays valid until the frame has ended.

Configuration inputs are expected to stay constant while frames flow. Input arrives as one byte per `in_valid` cycle with start and end markers. Gaps between bytes are allowed.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With `wide_addr` low, the address field is the single first byte of a frame, and it is compared with `pri_lo` under `pri_mask_lo`.
- R2: With `wide_addr` high, the address field is two bytes. The first is compared with `pri_hi` (mask `pri_mask_hi`) or `alt_hi`, and the second with `pri_lo` (mask `pri_mask_lo`) or `alt_lo`. Both bytes of a pair must match for that pair to hit.
- R3: A mask bit at 1 makes that bit position of the primary pair always match. An all-zero mask gives an exact comparison.
- R4: The secondary pair (`alt_lo`/`alt_hi`) is always compared exactly, and the mask inputs have no effect on it.
- R5: When `group_en` is high, a first address byte of 0xFE or 0xFC is accepted as a group address in either width mode. When `group_en` is low, these values get no special treatment.
- R6: `match_kind` encodes the decision as 0 = no match, 1 = primary pair, 2 = secondary pair, 3 = group. When several apply, the primary pair wins over the secondary pair, and the secondary pair wins over the group.
- R7: With `keep_addr` high, an accepted frame is output whole. The address bytes come first, `out_sof` is set on the first output byte and `out_eof` on the last.
- R8: With `keep_addr` low, the address bytes of an accepted frame are removed. `out_sof` marks the first byte after the address field.
- R9: A frame whose decision is 0 produces no output bytes.
- R10: `match_valid` and `match_kind` update on the clock edge that accepts the last address byte. They stay constant during the rest of the frame and return low one edge after the edge that accepts the end-of-frame byte.
- R11: Output bytes keep input order, with or without idle gaps, and frames sent back to back come out complete and in sequence.
- R12: A frame that ends before its address field is complete produces neither output nor a decision. A start marker in mid-frame abandons the old frame and begins a new one.
- R13: After reset, `out_valid` and `match_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| wide_addr | input | 1 | 1 = two-byte address field, 0 = one byte |
| group_en | input | 1 | Enable fixed group address acceptance |
| keep_addr | input | 1 | 1 = forward address bytes, 0 = strip them |
| pri_lo | input | 8 | Primary pair, low byte |
| pri_hi | input | 8 | Primary pair, high byte |
| pri_mask_lo | input | 8 | Wildcard mask for `pri_lo` |
| pri_mask_hi | input | 8 | Wildcard mask for `pri_hi` |
| alt_lo | input | 8 | Secondary pair, low byte |
| alt_hi | input | 8 | Secondary pair, high byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Last forwarded byte of a frame |
| match_valid | output | 1 | Decision for the current frame is valid |
| match_kind | output | 2 | Decision code (see R6) |

## Verification
The address stage is driven with exact hits, hits that only succeed through mask bits, and near misses one bit away under a zero mask. Together these separate true wildcard behaviour from accidental matching. Values that match both pairs, or a pair and a group code, expose the priority order. A secondary-pair value that differs only in a masked bit shows the mask does not leak into that pair. Streams are sent back to back, with idle gaps, as one-byte frames, as frames shorter than the address field, and as frames cut short by a new start marker. These cases distinguish the one-byte skew path used when two address bytes are released at once from the ordinary pass-through path.

// File: rtl/haf_pkg.sv
package haf_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  sof;
    logic  eof;
    byte_t data;
  } beat_t;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PAIR1 = 2'd1,
    KIND_PAIR2 = 2'd2,
    KIND_GROUP = 2'd3
  } kind_e;

  // Bits set in 'wild' are excluded from the comparison.
  function automatic logic masked_eq(byte_t rx, byte_t ref_b, byte_t wild);
    return ((rx ^ ref_b) & ~wild) == '0;
  endfunction

  function automatic logic is_group(byte_t rx, byte_t ga, byte_t gb);
    return (rx == ga) || (rx == gb);
  endfunction
endpackage

// File: rtl/haf_compare.sv
module haf_compare
  import haf_pkg::*;
#(
  parameter byte_t GRP_A = 8'hFE,
  parameter byte_t GRP_B = 8'hFC
) (
  input  logic  wide_mode,
  input  logic  group_en,
  input  byte_t first_b,
  input  byte_t second_b,
  input  byte_t pri_lo,
  input  byte_t pri_hi,
  input  byte_t pri_mask_lo,
  input  byte_t pri_mask_hi,
  input  byte_t alt_lo,
  input  byte_t alt_hi,
  output kind_e kind
);
  logic pair1_hit, pair2_hit, group_hit;

  always_comb begin
    if (wide_mode) begin
      pair1_hit = masked_eq(first_b, pri_hi, pri_mask_hi) &&
                  masked_eq(second_b, pri_lo, pri_mask_lo);
      pair2_hit = (first_b == alt_hi) && (second_b == alt_lo);
    end else begin
      pair1_hit = masked_eq(first_b, pri_lo, pri_mask_lo);
      pair2_hit = (first_b == alt_lo);
    end
  end

  assign group_hit = group_en && is_group(first_b, GRP_A, GRP_B);

  always_comb begin
    if (pair1_hit)      kind = KIND_PAIR1;
    else if (pair2_hit) kind = KIND_PAIR2;
    else if (group_hit) kind = KIND_GROUP;
    else                kind = KIND_NONE;
  end
endmodule

// File: rtl/haf_ctrl.sv
module haf_ctrl
  import haf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  byte_t in_data,
  input  logic  in_sof,
  input  logic  in_eof,
  input  logic  wide_mode,
  input  logic  keep_addr,
  input  kind_e kind,
  output byte_t cmp_first,
  output byte_t cmp_second,
  output logic  n0_v,
  output beat_t n0,
  output logic  n1_v,
  output beat_t n1,
  output logic  stat_valid,
  output kind_e stat_kind
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT2, S_PASS, S_DROP} st_e;

  st_e   state_q, state_d;
  byte_t hold_q;
  logic  lead_q;
  logic  last_q;

  // named events
  logic start_ev, second_ev, decide_ev, hit, accept_ev, body_ev;

  assign start_ev   = in_valid & in_sof;
  assign second_ev  = in_valid & ~in_sof & (state_q == S_WAIT2);
  assign decide_ev  = (start_ev & ~wide_mode) | second_ev;
  assign hit        = (kind != KIND_NONE);
  assign accept_ev  = decide_ev & hit;
  assign body_ev    = in_valid & ~in_sof & (state_q == S_PASS);
  assign cmp_first  = second_ev ? hold_q : in_data;
  assign cmp_second = in_data;

  always_comb begin
    n0_v = 1'b0;
    n0   = '0;
    n1_v = 1'b0;
    n1   = '0;
    if (accept_ev && keep_addr) begin
      n0_v = 1'b1;
      if (second_ev) begin
        n0   = '{sof: 1'b1, eof: 1'b0, data: hold_q};
        n1_v = 1'b1;
        n1   = '{sof: 1'b0, eof: in_eof, data: in_data};
      end else begin
        n0 = '{sof: 1'b1, eof: in_eof, data: in_data};
      end
    end else if (body_ev) begin
      n0_v = 1'b1;
      n0   = '{sof: lead_q, eof: in_eof, data: in_data};
    end
  end

  always_comb begin
    state_d = state_q;
    if (start_ev) begin
      if (in_eof)         state_d = S_IDLE;
      else if (wide_mode) state_d = S_WAIT2;
      else                state_d = hit ? S_PASS : S_DROP;
    end else if (in_valid) begin
      if (state_q == S_WAIT2) state_d = in_eof ? S_IDLE : (hit ? S_PASS : S_DROP);
      else if (in_eof)        state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      hold_q     <= '0;
      lead_q     <= 1'b0;
      last_q     <= 1'b0;
      stat_valid <= 1'b0;
      stat_kind  <= KIND_NONE;
    end else begin
      state_q <= state_d;
      if (start_ev) hold_q <= in_data;
      if (accept_ev && !keep_addr)  lead_q <= 1'b1;
      else if (body_ev || start_ev) lead_q <= 1'b0;
      if (decide_ev) begin
        stat_valid <= 1'b1;
        stat_kind  <= kind;
        last_q     <= in_eof;
      end else if (start_ev) begin
        stat_valid <= 1'b0;
        last_q     <= 1'b0;
      end else if (in_valid && in_eof && stat_valid) begin
        last_q <= 1'b1;
      end else if (last_q) begin
        stat_valid <= 1'b0;
        last_q     <= 1'b0;
      end
    end
  end

  // R10
  decide_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_ev |=> stat_valid);

  // R10
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !decide_ev) |=> $stable(stat_kind));
endmodule

// File: rtl/haf_outstage.sv
module haf_outstage
  import haf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  n0_v,
  input  beat_t n0,
  input  logic  n1_v,
  input  beat_t n1,
  output logic  out_v,
  output beat_t out_b
);
  logic  carry_v;
  beat_t carry_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_b   <= '0;
      carry_v <= 1'b0;
      carry_b <= '0;
    end else begin
      out_v <= carry_v | n0_v;
      out_b <= carry_v ? carry_b : n0;
      if (carry_v) begin
        carry_v <= n0_v;
        carry_b <= n0;
      end else begin
        carry_v <= n1_v;
        carry_b <= n1;
      end
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_v && n1_v));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import haf_pkg::*;
#(
  parameter byte_t GRP_A = 8'hFE,
  parameter byte_t GRP_B = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              wide_addr,
  input  logic              group_en,
  input  logic              keep_addr,
  input  logic [BYTE_W-1:0] pri_lo,
  input  logic [BYTE_W-1:0] pri_hi,
  input  logic [BYTE_W-1:0] pri_mask_lo,
  input  logic [BYTE_W-1:0] pri_mask_hi,
  input  logic [BYTE_W-1:0] alt_lo,
  input  logic [BYTE_W-1:0] alt_hi,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              match_valid,
  output logic [1:0]        match_kind
);
  byte_t cmp_first, cmp_second;
  kind_e kind, stat_kind;
  logic  n0_v, n1_v, out_v;
  beat_t n0, n1, out_b;

  haf_compare #(.GRP_A(GRP_A), .GRP_B(GRP_B)) u_cmp (
    .wide_mode(wide_addr), .group_en(group_en),
    .first_b(cmp_first), .second_b(cmp_second),
    .pri_lo(pri_lo), .pri_hi(pri_hi),
    .pri_mask_lo(pri_mask_lo), .pri_mask_hi(pri_mask_hi),
    .alt_lo(alt_lo), .alt_hi(alt_hi),
    .kind(kind)
  );

  haf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .wide_mode(wide_addr), .keep_addr(keep_addr), .kind(kind),
    .cmp_first(cmp_first), .cmp_second(cmp_second),
    .n0_v(n0_v), .n0(n0), .n1_v(n1_v), .n1(n1),
    .stat_valid(match_valid), .stat_kind(stat_kind)
  );

  haf_outstage u_out (
    .clk(clk), .rst_n(rst_n),
    .n0_v(n0_v), .n0(n0), .n1_v(n1_v), .n1(n1),
    .out_v(out_v), .out_b(out_b)
  );

  assign out_valid  = out_v;
  assign out_data   = out_b.data;
  assign out_sof    = out_b.sof;
  assign out_eof    = out_b.eof;
  assign match_kind = stat_kind;

  // R7
  sof_under_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (match_valid && match_kind != 2'd0));

  // R9
  rejected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && match_kind == 2'd0) |-> !out_valid);
endmodule

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic wide_addr = 1'b0, group_en = 1'b1, keep_addr = 1'b1;
  logic [7:0] pri_lo = 8'h5A, pri_hi = 8'h31, pri_mask_lo = '0, pri_mask_hi = '0;
  logic [7:0] alt_lo = 8'hC3, alt_hi = 8'h77;
  logic out_valid, out_sof, out_eof, match_valid;
  logic [7:0] out_data;
  logic [1:0] match_kind;

  int total = 0, fails = 0;
  logic [7:0] frm[$];
  logic [9:0] cap_q[$], exp_q[$];
  logic [1:0] kind_q[$];
  logic prev_mv = 1'b0;

  always #5 clk = ~clk;

  hdlc_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .wide_addr(wide_addr), .group_en(group_en),
    .keep_addr(keep_addr), .pri_lo(pri_lo), .pri_hi(pri_hi),
    .pri_mask_lo(pri_mask_lo), .pri_mask_hi(pri_mask_hi), .alt_lo(alt_lo),
    .alt_hi(alt_hi), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .match_valid(match_valid), .match_kind(match_kind)
  );

  always @(negedge clk) begin
    if (out_valid) cap_q.push_back({out_sof, out_eof, out_data});
    if (match_valid && !prev_mv) kind_q.push_back(match_kind);
    prev_mv = match_valid;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bitwise restatement of the compare rules (R1..R6)
  function automatic int bench_kind(input logic [7:0] b0, input logic [7:0] b1);
    bit p1 = 1, p2;
    for (int i = 0; i < 8; i++) begin
      if (wide_addr) begin
        if (!pri_mask_hi[i] && b0[i] != pri_hi[i]) p1 = 0;
        if (!pri_mask_lo[i] && b1[i] != pri_lo[i]) p1 = 0;
      end else if (!pri_mask_lo[i] && b0[i] != pri_lo[i]) p1 = 0;
    end
    p2 = wide_addr ? (b0 == alt_hi && b1 == alt_lo) : (b0 == alt_lo);
    if (p1) return 1;
    if (p2) return 2;
    if (group_en && (b0 == 8'hFE || b0 == 8'hFC)) return 3;
    return 0;
  endfunction

  task automatic drive_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  task automatic add_expected(input logic [7:0] f[$]);
    int alen = wide_addr ? 2 : 1;
    int k;
    int first;
    if (f.size() < alen) return;
    k = bench_kind(f[0], (f.size() > 1) ? f[1] : 8'h00);
    if (k == 0) return;
    first = keep_addr ? 0 : alen;
    for (int i = first; i < f.size(); i++)
      exp_q.push_back({(i == first) ? 1'b1 : 1'b0, (i == f.size() - 1) ? 1'b1 : 1'b0, f[i]});
  endtask

  task automatic cmp_stream(input string req);
    int av = 0, ev = 0;
    chk(req, "stream length", cap_q.size(), exp_q.size());
    for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
      if (cap_q[i] !== exp_q[i]) begin av = cap_q[i]; ev = exp_q[i]; break; end
    chk(req, "stream content", av, ev);
  endtask

  // one frame from frm, with 'gap' idle cycles after every byte
  task automatic run_case(input string rk, input string ro, input int gap);
    int alen = wide_addr ? 2 : 1;
    int n = frm.size();
    int k, got;
    cap_q = {}; kind_q = {}; exp_q = {};
    k = bench_kind(frm[0], (n > 1) ? frm[1] : 8'h00);
    for (int i = 0; i < n; i++) begin
      drive_byte(frm[i], i == 0, i == n - 1);
      idle(gap);
    end
    idle(6);
    add_expected(frm);
    if (n >= alen) begin
      got = (kind_q.size() == 1) ? int'(kind_q[0]) : -1;
      chk(rk, "match kind", got, k);
    end else chk(rk, "decision count", kind_q.size(), 0);
    cmp_stream(ro);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13", "out_valid in reset", out_valid, 0);
    chk("R13", "match_valid in reset", match_valid, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R13", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_narrow();
    wide_addr = 0; keep_addr = 1; pri_mask_lo = '0;
    frm = '{8'h5A, 8'h11, 8'h22, 8'h33}; run_case("R1", "R7", 0);
    frm = '{8'h5A};                      run_case("R1", "R7", 0);
    pri_mask_lo = 8'h0F; keep_addr = 0;
    frm = '{8'h55, 8'hAA, 8'hBB};        run_case("R3", "R8", 0);
    pri_mask_lo = '0; keep_addr = 1;
    frm = '{8'h5B, 8'h01, 8'h02};        run_case("R3", "R9", 0);
  endtask

  task automatic t_alt_pair();
    wide_addr = 0; keep_addr = 1; pri_mask_lo = 8'h01;
    frm = '{8'hC2, 8'h01, 8'h02};        run_case("R4", "R9", 0);
    frm = '{8'hC3, 8'h03};               run_case("R4", "R7", 0);
    pri_mask_lo = '0;
  endtask

  task automatic t_wide();
    wide_addr = 1; keep_addr = 1;
    frm = '{8'h31, 8'h5A, 8'h44, 8'h55, 8'h66}; run_case("R2", "R7", 0);
    frm = '{8'h31, 8'h5B, 8'h44};               run_case("R2", "R9", 0);
    keep_addr = 0;
    frm = '{8'h77, 8'hC3, 8'h09};               run_case("R2", "R8", 0);
    pri_mask_hi = 8'hF0; keep_addr = 1;
    frm = '{8'hA1, 8'h5A, 8'h0E};               run_case("R3", "R7", 0);
    pri_mask_hi = '0;
    frm = '{8'h31, 8'h5A, 8'h01, 8'h02, 8'h03}; run_case("R11", "R11", 2);
  endtask

  task automatic t_group();
    wide_addr = 0; keep_addr = 1; group_en = 1;
    frm = '{8'hFE, 8'h10, 8'h20};  run_case("R5", "R7", 0);
    frm = '{8'hFC, 8'h10};         run_case("R5", "R7", 1);
    wide_addr = 1;
    frm = '{8'hFC, 8'h00, 8'h30};  run_case("R5", "R7", 0);
    wide_addr = 0; group_en = 0;
    frm = '{8'hFE, 8'h10, 8'h20};  run_case("R5", "R9", 0);
    group_en = 1;
  endtask

  task automatic t_priority();
    wide_addr = 0; keep_addr = 1;
    alt_lo = 8'h5A;
    frm = '{8'h5A, 8'h01};  run_case("R6", "R7", 0);
    alt_lo = 8'hFE;
    frm = '{8'hFE, 8'h02};  run_case("R6", "R7", 0);
    alt_lo = 8'hC3;
  endtask

  task automatic t_back_to_back();
    logic [7:0] fa[$], fb[$];
    wide_addr = 1; keep_addr = 1;
    cap_q = {}; exp_q = {};
    fa = '{8'h31, 8'h5A, 8'hA1};
    fb = '{8'h77, 8'hC3, 8'hB1, 8'hB2};
    for (int i = 0; i < fa.size(); i++) drive_byte(fa[i], i == 0, i == fa.size() - 1);
    for (int i = 0; i < fb.size(); i++) drive_byte(fb[i], i == 0, i == fb.size() - 1);
    idle(6);
    add_expected(fa);
    add_expected(fb);
    cmp_stream("R11");
  endtask

  task automatic t_short_abort();
    logic [7:0] fb[$];
    wide_addr = 1; keep_addr = 1;
    frm = '{8'h31}; run_case("R12", "R12", 0);
    cap_q = {}; kind_q = {}; exp_q = {};
    drive_byte(8'h31, 1, 0);
    drive_byte(8'h5B, 0, 0);
    drive_byte(8'h01, 0, 0);
    fb = '{8'h31, 8'h5A, 8'h02};
    for (int i = 0; i < fb.size(); i++) drive_byte(fb[i], i == 0, i == fb.size() - 1);
    idle(6);
    add_expected(fb);
    cmp_stream("R12");
    chk("R12", "decisions seen", kind_q.size(), 2);
    chk("R12", "restarted frame kind", (kind_q.size() == 2) ? int'(kind_q[1]) : -1, 1);
  endtask

  task automatic t_status_timing();
    wide_addr = 0; keep_addr = 1;
    idle(2);
    chk("R10", "status before frame", match_valid, 0);
    drive_byte(8'h5A, 1, 0);
    drive_byte(8'h01, 0, 0);
    chk("R10", "status after address byte", {match_valid, match_kind}, 3'b101);
    chk("R7", "first output byte", {out_valid, out_sof, out_data}, {2'b11, 8'h5A});
    drive_byte(8'h02, 0, 1);
    idle(1);
    chk("R10", "status after eof edge", match_valid, 1);
    idle(1);
    chk("R10", "status one edge later", match_valid, 0);
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_narrow();
    t_alt_pair();
    t_wide();
    t_group();
    t_priority();
    t_back_to_back();
    t_short_abort();
    t_status_timing();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule